// File: doc/BRIEF.md
# Target Reset Pulse Sequencer

This block drives a controlled reset of an attached target through two open-drain lines: the target's reset line and its single-wire debug line. A host raises `start_i` with a mode bit. The block first makes sure the reset line is not held low from outside. In special (debug) mode it pulls the debug line low and lets it settle. It then drives reset low for a fixed number of cycles, releases it, and checks that the line rises again. In special mode it waits a settle time, drives the debug line actively high for a short burst and then lets it float. A last settle interval keeps the debug line quiet before other debug traffic may start.

Each open-drain pin appears as an output-enable and an output value, plus a sampled input. The reset input passes through a two-stage synchronizer. Outside a sequence, a falling edge on that input sets a sticky "reset seen" flag. The flag is masked while the sequence runs and is cleared when a sequence completes cleanly. A single down-counter times every interval. The settle, pulse, high-burst and timeout lengths are parameters in clock cycles.

Top module: `tgt_rst_seq`

## Requirements
- R1: Out of reset the block is idle: busy_o, done_o, err_o and rst_seen_o are low, and neither line is driven (rst_oe_o = 0, dbg_oe_o = 0).
- R2: A start pulse while idle captures mode_i (0 = special, 1 = normal), and busy_o is high from the next cycle until the sequence ends. A start pulse while busy is ignored and does not change the captured mode or start a second sequence.
- R3: With the debug line released, the block waits for the synchronized reset input to be high. If it stays low for TMO_CYC cycles, the sequence ends with done_o and err_o high and reset is never driven.
- R4: In special mode the debug line is driven low (dbg_oe_o = 1, dbg_out_o = 0) for exactly SETTLE_CYC cycles before reset is driven. It stays low in every cycle of the reset pulse.
- R5: In normal mode the debug line is never driven.
- R6: Reset is driven low (rst_oe_o = 1 with rst_out_o = 0) for exactly PULSE_CYC consecutive cycles, then released.
- R7: After release, if the reset input does not return high within TMO_CYC cycles, the sequence ends with done_o and err_o high and both lines released.
- R8: In special mode, after reset has risen, the debug line stays low for at least SETTLE_CYC more cycles. It is then driven high (dbg_out_o = 1) for exactly HIGH_CYC cycles and released.
- R9: After the last line activity, a quiet interval of at least SETTLE_CYC cycles with nothing driven precedes completion. In special mode this interval is exactly SETTLE_CYC cycles. Completion is a one-cycle done_o pulse with err_o low.
- R10: While idle, a falling edge of the synchronized reset input sets rst_seen_o, which then holds. Edges seen while busy do not set it. A sequence that completes without error clears it, and an error exit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a reset sequence (sampled while idle) |
| mode_i | input | 1 | 0 = special debug mode, 1 = normal mode |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Reset stuck low; valid with done_o, held until next start |
| rst_seen_o | output | 1 | Sticky flag: external reset assertion observed |
| rst_oe_o | output | 1 | Reset line output enable |
| rst_out_o | output | 1 | Reset line output value |
| rst_in_i | input | 1 | Reset line sampled level (asynchronous) |
| dbg_oe_o | output | 1 | Debug line output enable |
| dbg_out_o | output | 1 | Debug line output value |

## Verification
The external-reset detector and the start of a sequence can act on the same clock edge. A reset fall that becomes visible in the last idle cycle is recorded, even though the start accepted on that edge masks every later edge. The bench lines this up by pulling the reset line low and raising start so that the synchronized fall and the start are sampled together. It expects rst_seen_o high during the sequence, a pre-check that waits out the external low, and a clean finish that clears the flag. A separate run injects an external fall well inside a special-mode sequence and requires the flag to stay low throughout.

// File: rtl/tgt_rst_pkg.sv
package tgt_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRECHK = 3'd1,
    ST_DBGLO  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_RISE   = 3'd4,
    ST_POSTST = 3'd5,
    ST_DBGHI  = 3'd6,
    ST_QUIET  = 3'd7
  } seq_st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tgt_rst_sync.sv
module tgt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      lvl_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign level_o = lvl_q;
  assign fall_o  = prev_q & ~lvl_q;
endmodule

// File: rtl/tgt_rst_timer.sv
module tgt_rst_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tgt_rst_fsm.sv
module tgt_rst_fsm
  import tgt_rst_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned PULSE_CYC  = 16,
  parameter int unsigned HIGH_CYC   = 2,
  parameter int unsigned TMO_CYC    = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          rst_hi_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          seen_clr_o,
  output logic          mode_o,
  output logic          rst_drv_o,
  output logic          dbg_drv_o,
  output logic          dbg_val_o
);
  localparam logic [CW-1:0] LD_SETTLE = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] LD_PULSE  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] LD_HIGH   = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] LD_TMO    = CW'(TMO_CYC - 1);

  seq_st_e st_q, st_d;
  logic    mode_q, mode_d;
  logic    done_q, err_q, err_d;
  logic    ok_end, bad_end, accept;

  always_comb begin
    st_d       = st_q;
    mode_d     = mode_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    ok_end     = 1'b0;
    bad_end    = 1'b0;
    accept     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        accept = 1'b1; mode_d = mode_i; st_d = ST_PRECHK;
        tmr_load_o = 1'b1; tmr_val_o = LD_TMO;
      end
      ST_PRECHK: if (rst_hi_i) begin
        tmr_load_o = 1'b1;
        if (!mode_q) begin st_d = ST_DBGLO; tmr_val_o = LD_SETTLE; end
        else         begin st_d = ST_PULSE; tmr_val_o = LD_PULSE;  end
      end else if (tmr_zero_i) begin
        bad_end = 1'b1; st_d = ST_IDLE;
      end
      ST_DBGLO: if (tmr_zero_i) begin
        st_d = ST_PULSE; tmr_load_o = 1'b1; tmr_val_o = LD_PULSE;
      end
      ST_PULSE: if (tmr_zero_i) begin
        st_d = ST_RISE; tmr_load_o = 1'b1; tmr_val_o = LD_TMO;
      end
      ST_RISE: if (rst_hi_i) begin
        st_d = mode_q ? ST_QUIET : ST_POSTST;
        tmr_load_o = 1'b1; tmr_val_o = LD_SETTLE;
      end else if (tmr_zero_i) begin
        bad_end = 1'b1; st_d = ST_IDLE;
      end
      ST_POSTST: if (tmr_zero_i) begin
        st_d = ST_DBGHI; tmr_load_o = 1'b1; tmr_val_o = LD_HIGH;
      end
      ST_DBGHI: if (tmr_zero_i) begin
        st_d = ST_QUIET; tmr_load_o = 1'b1; tmr_val_o = LD_SETTLE;
      end
      ST_QUIET: if (tmr_zero_i) begin
        ok_end = 1'b1; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    err_d = accept ? 1'b0 : (bad_end ? 1'b1 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      done_q <= ok_end | bad_end;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rst_drv_o = (st_q == ST_PULSE);
    dbg_val_o = (st_q == ST_DBGHI);
    unique case (st_q)
      ST_DBGLO, ST_POSTST, ST_DBGHI: dbg_drv_o = 1'b1;
      ST_PULSE, ST_RISE:             dbg_drv_o = ~mode_q;
      default:                       dbg_drv_o = 1'b0;
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign seen_clr_o = ok_end;
  assign mode_o     = mode_q;
endmodule

// File: rtl/tgt_rst_seq.sv
module tgt_rst_seq
  import tgt_rst_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned PULSE_CYC  = 16,
  parameter int unsigned HIGH_CYC   = 2,
  parameter int unsigned TMO_CYC    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_i,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic rst_seen_o,
  output logic rst_oe_o,
  output logic rst_out_o,
  input  logic rst_in_i,
  output logic dbg_oe_o,
  output logic dbg_out_o
);
  localparam int unsigned MAX_CYC = max2(max2(SETTLE_CYC, PULSE_CYC), max2(HIGH_CYC, TMO_CYC));
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          rst_hi, rst_fall, tmr_zero, tmr_load, seen_clr, mode_q;
  logic          rst_drv, dbg_drv, dbg_val;
  logic [CW-1:0] tmr_val;
  logic          seen_q, seen_d;

  tgt_rst_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rst_in_i), .level_o(rst_hi), .fall_o(rst_fall)
  );

  tgt_rst_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  tgt_rst_fsm #(
    .CW(CW), .SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC),
    .HIGH_CYC(HIGH_CYC), .TMO_CYC(TMO_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .rst_hi_i(rst_hi), .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .seen_clr_o(seen_clr),
    .mode_o(mode_q), .rst_drv_o(rst_drv), .dbg_drv_o(dbg_drv), .dbg_val_o(dbg_val)
  );

  always_comb begin
    if (seen_clr)                 seen_d = 1'b0;
    else if (rst_fall && !busy_o) seen_d = 1'b1;
    else                          seen_d = seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign rst_seen_o = seen_q;
  assign rst_oe_o   = rst_drv;
  assign rst_out_o  = ~rst_drv;
  assign dbg_oe_o   = dbg_drv;
  assign dbg_out_o  = dbg_val;
endmodule

// File: rtl/tgt_rst_chk.sv
module tgt_rst_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic rst_seen_o,
  input logic rst_oe_o,
  input logic rst_out_o,
  input logic dbg_oe_o,
  input logic mode_q
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rst_oe_o && !dbg_oe_o)); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o); // R3
  AST_NORMAL_DBG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q) |-> !dbg_oe_o); // R5
  AST_RST_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_oe_o |-> !rst_out_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_SEEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rst_seen_o) |=> !rst_seen_o); // R10
endmodule

bind tgt_rst_seq tgt_rst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .rst_seen_o(rst_seen_o), .rst_oe_o(rst_oe_o), .rst_out_o(rst_out_o),
  .dbg_oe_o(dbg_oe_o), .mode_q(mode_q)
);

// File: tb/tgt_rst_seq_test.sv
module tgt_rst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SET = 8;
  localparam int PUL = 16;
  localparam int HI  = 2;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic stuck = 1'b0, ext = 1'b0;
  logic busy, done, err, seen, rst_oe, rst_out, rst_in, dbg_oe, dbg_out;
  int   checks = 0, fails = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rst_in = ~((rst_oe & ~rst_out) | stuck | ext);

  tgt_rst_seq #(.SETTLE_CYC(SET), .PULSE_CYC(PUL), .HIGH_CYC(HI), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .busy_o(busy),
    .done_o(done), .err_o(err), .rst_seen_o(seen), .rst_oe_o(rst_oe), .rst_out_o(rst_out),
    .rst_in_i(rst_in), .dbg_oe_o(dbg_oe), .dbg_out_o(dbg_out)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Runs one sequence and measures it at the ports.
  task automatic run_seq(input bit md, input bit st_pre, input bit st_post,
                         input bit poke_start, input bit poke_ext,
                         output int busy_n, output int pulse_n, output int pre_lo,
                         output int hi_n, output int quiet, output int post_lo,
                         output bit dbg_bad, output bit seen_bad, output bit e);
    bit seen_rst = 0, rst_done = 0;
    int it = 0, ext_left = 0;
    busy_n = 0; pulse_n = 0; pre_lo = 0; hi_n = 0; quiet = 0; post_lo = 0;
    dbg_bad = 0; seen_bad = 0;
    stuck = st_pre;
    mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && it < 2000) begin
      it++;
      if (poke_start && it == 5) begin start = 1'b1; mode = ~md; end
      else begin start = 1'b0; mode = md; end
      if (busy) busy_n++;
      if (rst_oe) begin
        pulse_n++; seen_rst = 1;
        if (!md && !(dbg_oe && !dbg_out)) dbg_bad = 1;
        if (st_post) stuck = 1'b1;
      end else if (seen_rst) rst_done = 1;
      if (!seen_rst && dbg_oe && !dbg_out) pre_lo++;
      if (rst_done && dbg_oe && !dbg_out) post_lo++;
      if (dbg_oe && dbg_out) hi_n++;
      if (md && dbg_oe) dbg_bad = 1;
      if (busy && !rst_oe && !dbg_oe) quiet++;
      if (rst_oe || dbg_oe) quiet = 0;
      if (poke_ext && !seen_rst && dbg_oe && ext_left == 0 && pre_lo == 2) ext_left = 3;
      ext = (ext_left > 0);
      if (ext_left > 0) ext_left--;
      if (poke_ext && seen) seen_bad = 1;
      @(negedge clk);
    end
    start = 1'b0; mode = md; ext = 1'b0;
    e = err;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err && !seen, "R1 status idle", {busy, done, err, seen}, 0);
    chk(!rst_oe && !dbg_oe, "R1 lines released", {rst_oe, dbg_oe}, 0);
  endtask

  task automatic t_normal(input bit poke);
    int b, p, pl, h, q, pol; bit db, sb, e;
    run_seq(1'b1, 0, 0, poke, 0, b, p, pl, h, q, pol, db, sb, e);
    chk(done === 1'b1 && !e, "R9 normal clean done", {done, e}, 2);
    chk(p == PUL, "R6 normal pulse length", p, PUL);
    chk(!db && h == 0 && pl == 0, "R5 normal debug untouched", {db, 1'b0} + h + pl, 0);
    chk(q >= SET, "R9 normal quiet interval", q, SET);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    idle(3);
    chk(!busy, "R2 start while busy ignored", busy, 0);
  endtask

  task automatic t_special(input bit poke_ext);
    int b, p, pl, h, q, pol; bit db, sb, e;
    run_seq(1'b0, 0, 0, 0, poke_ext, b, p, pl, h, q, pol, db, sb, e);
    chk(done === 1'b1 && !e, "R9 special clean done", {done, e}, 2);
    chk(pl == SET, "R4 debug low before pulse", pl, SET);
    chk(!db, "R4 debug low during pulse", db, 0);
    chk(p == PUL, "R6 special pulse length", p, PUL);
    chk(pol >= SET, "R8 settle after rise", pol, SET);
    chk(h == HI, "R8 debug high burst", h, HI);
    chk(q == SET, "R9 special quiet interval", q, SET);
    if (poke_ext) chk(!sb, "R10 edge masked while busy", sb, 0);
    idle(2);
    chk(!seen, "R10 flag clear after clean run", seen, 0);
  endtask

  task automatic t_stuck_pre;
    int b, p, pl, h, q, pol; bit db, sb, e;
    stuck = 1'b1;
    idle(5);
    run_seq(1'b0, 1, 0, 0, 0, b, p, pl, h, q, pol, db, sb, e);
    chk(done && e, "R3 stuck before pulse error", {done, e}, 3);
    chk(p == 0, "R3 reset never driven", p, 0);
    chk(b == TMO, "R3 timeout length", b, TMO);
    chk(seen, "R10 idle fall sets flag, error keeps it", seen, 1);
    stuck = 1'b0;
    idle(4);
  endtask

  task automatic t_stuck_post;
    int b, p, pl, h, q, pol; bit db, sb, e;
    run_seq(1'b0, 0, 1, 0, 0, b, p, pl, h, q, pol, db, sb, e);
    chk(done && e, "R7 stuck after pulse error", {done, e}, 3);
    chk(!rst_oe && !dbg_oe, "R7 lines released after error", {rst_oe, dbg_oe}, 0);
    chk(h == 0, "R7 no high burst on error", h, 0);
    stuck = 1'b0;
    idle(4);
    chk(err, "R7 err held until next start", err, 1);
  endtask

  task automatic t_seen_idle;
    ext = 1'b1; idle(4); ext = 1'b0; idle(4);
    chk(seen, "R10 idle fall sets flag", seen, 1);
    idle(10);
    chk(seen, "R10 flag sticky", seen, 1);
  endtask

  // Synchronized fall and start sampled on the same edge.
  task automatic t_collide;
    int it = 0;
    ext = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); mode = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(seen && busy, "R10 fall at start edge recorded", {seen, busy}, 3);
    idle(5); ext = 1'b0;
    while (!done && it < 2000) begin it++; @(negedge clk); end
    chk(done && !err, "R3 pre-check waits out external low", {done, err}, 2);
    idle(1);
    chk(!seen, "R10 cleared by clean finish", seen, 0);
  endtask

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_normal(1'b0);
    t_normal(1'b1);
    t_special(1'b0);
    t_special(1'b1);
    t_stuck_pre();
    t_special(1'b0);
    t_stuck_post();
    t_seen_idle();
    t_special(1'b0);
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule